// File: doc/BRIEF.md
# Chainable Reload Down-Counter Bank

This block holds four 8-bit interval timers. Each timer counts down by one on every clock cycle in which its own tick enable is high. When it steps down from zero it reloads from its base register and gives a one-cycle underflow pulse. That pulse can feed an interrupt controller directly.

A timer set to the cascade source stops counting on its own tick. It instead takes the borrow of the timer beneath it, so two, three or four neighbouring timers act as one 16-, 24- or 32-bit counter. The timer that starts the chain holds the least significant byte. Only the highest timer of the chain reports the underflow.

Software reaches the mode, base and counter registers over a simple byte-addressed register bus. Both reads and writes complete in one cycle. Illegal requests are refused and flagged on a one-cycle error output.

Top module: `tmr_cascade_bank`

## Requirements
- R1: After reset every mode, base and counter register reads as zero, and `err` and `uflow` are low.
- R2: The register map has three groups, with n being the timer number 0..3. The mode register of timer n is at address 0x00+n, its base register at 0x10+n, and its counter at 0x20+n. In a mode byte, bit 7 enables counting, bit 6 requests a copy of the base into the counter, and bits 1:0 pick the count source. Source code 3 means cascade from timer n-1; every other code means the timer's own `tick_en` bit. Mode registers read back exactly as they were last written.
- R3: The block refuses a mode write in any of these cases: bit 7 and bit 6 are both set, any of bits 5:2 is set, source code 3 is written to timer 0, or the access is not one byte. A refused write sets `err` in the next cycle and leaves the register unchanged.
- R4: A running timer with base value B decrements once per cycle in which its `tick_en` bit is high. The tick that finds it at zero reloads B and raises its `uflow` bit for exactly one cycle, so pulses come every B+1 ticks.
- R5: While a timer is stopped, a base write also sets its counter. While it runs, a base write leaves the counter alone, and the new value is used from the next reload on.
- R6: The cascaded timers above a started timer form one counter, with the starting timer as the lowest byte. Their `tick_en` bits have no effect. When the combined value steps down from zero, every byte of the chain reloads and only the highest timer of the chain pulses `uflow`.
- R7: Starting a timer (bit 7 set, source not cascade) is refused with `err` if any cascaded timer directly above it has bit 7 clear. The timer then does not count.
- R8: A start request whose combined base is zero is accepted but leaves the timer stopped. A later tick does not decrement it and raises no `uflow`.
- R9: Reading the counter of a stopped timer returns its base value. Writing any counter address is refused with `err`.
- R10: Register accesses take `size` codes 0, 1 and 2 for 1, 2 and 4 bytes. A 1-byte access works at any timer, a 2-byte access only at timers 0 and 2, and a 4-byte access only at timer 0. In a multi-byte access the lower-numbered timer sits in the more significant byte. Any other size or unmapped address gives `err`, and a refused write changes nothing.
- R11: Clearing bit 7 stops the timer at once. A new start reloads the whole chain from the base registers before counting resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 4 | Per-timer count tick, one bit per timer |
| wr_en | input | 1 | Register write strobe (takes priority over read) |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the access |
| size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| wdata | input | 32 | Write data, right-aligned to the access size |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| err | output | 1 | One-cycle pulse for a refused access |
| uflow | output | 4 | One-cycle underflow pulse per timer |

## Verification
A broken borrow between bytes shows up in the multi-byte counter read on the first tick that wraps a low byte, such as 0x0100 stepping to 0x00FF. Wrong chain membership moves or duplicates the `uflow` pulse at the first underflow of the combined counter. A stale or wrongly chosen reload source stays hidden until the first reload. It then shows as a wrong counter value in the very next read, which is why every period is swept to its end and past it. A wrong run flag shows within one tick as a counter that moves when it must hold, or holds when it must move.

// File: rtl/tmr_cascade_bank.sv
module tmr_cascade_bank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  tick_en,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  addr,
  input  logic [1:0]  size,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        err,
  output logic [3:0]  uflow
);
  localparam int NT = 4;
  localparam int TW = 8;
  localparam int DW = NT * TW;
  localparam logic [1:0] SRC_CAS = 2'd3;

  logic [TW-1:0] mode [NT];
  logic [TW-1:0] base [NT];
  logic [TW-1:0] cnt  [NT];
  logic [NT-1:0] run;

  logic [NT-1:0] cas, act, allz, busy, stp, ufc, top;

  always_comb begin
    for (int i = 0; i < NT; i++) cas[i] = (i != 0) && (mode[i][1:0] == SRC_CAS);
    act[0]  = tick_en[0] && run[0];
    allz[0] = cnt[0] == '0;
    busy[0] = run[0];
    stp[0]  = act[0];
    for (int i = 1; i < NT; i++) begin
      if (cas[i]) begin
        act[i]  = act[i-1];
        allz[i] = (cnt[i] == '0) && allz[i-1];
        busy[i] = busy[i-1];
        stp[i]  = act[i-1] && allz[i-1];
      end else begin
        act[i]  = tick_en[i] && run[i];
        allz[i] = cnt[i] == '0;
        busy[i] = run[i];
        stp[i]  = act[i];
      end
    end
    top[NT-1] = 1'b1;
    ufc[NT-1] = act[NT-1] && allz[NT-1];
    for (int i = NT-2; i >= 0; i--) begin
      top[i] = !cas[i+1];
      ufc[i] = top[i] ? (act[i] && allz[i]) : ufc[i+1];
    end
  end

  wire [3:0] grp  = addr[7:4];
  wire [1:0] idx  = addr[1:0];
  wire       amap = (addr[3:2] == 2'b00) && (grp <= 4'd2);
  wire       szok = (size == 2'd0) || (size == 2'd1 && !idx[0]) || (size == 2'd2 && idx == 2'd0);
  wire [7:0] mv   = wdata[7:0];

  logic [NT-1:0] lanes;
  logic [TW-1:0] wb [NT];
  logic [DW-1:0] rv;

  always_comb begin
    int n, sh;
    logic [TW-1:0] rb;
    n  = 1 << size;
    rv = '0;
    for (int k = 0; k < NT; k++) begin
      lanes[k] = szok && (k >= int'(idx)) && (k < int'(idx) + n);
      sh       = lanes[k] ? (n - 1 - (k - int'(idx))) : 0;
      wb[k]    = TW'(wdata >> (TW * sh));
      case (grp)
        4'd0:    rb = mode[k];
        4'd1:    rb = base[k];
        default: rb = busy[k] ? cnt[k] : base[k];
      endcase
      if (lanes[k]) rv = rv | (DW'(rb) << (TW * sh));
    end
  end

  logic          mbad, start, nz, brk;
  logic [NT-1:0] chain;

  always_comb begin
    mbad  = (size != 2'd0) || (mv[7] && mv[6]) || (mv[5:2] != 4'd0) ||
            (idx == 2'd0 && mv[1:0] == SRC_CAS);
    start = mv[7] && (mv[1:0] != SRC_CAS);
    chain = '0;
    chain[idx] = 1'b1;
    nz  = base[idx] != '0;
    brk = 1'b0;
    for (int j = 1; j < NT; j++) begin
      if (j > int'(idx) && !brk) begin
        if (mode[j][1:0] == SRC_CAS) begin
          chain[j] = 1'b1;
          nz = nz || (base[j] != '0);
          if (start && !mode[j][7]) mbad = 1'b1;
        end else begin
          brk = 1'b1;
        end
      end
    end
  end

  wire wmode = wr_en && amap && grp == 4'd0 && !mbad;
  wire wbase = wr_en && amap && grp == 4'd1 && szok;
  wire werr  = wr_en && (!amap || grp == 4'd2 || (grp == 4'd0 && mbad) || (grp == 4'd1 && !szok));
  wire rsel  = rd_en && !wr_en;
  wire rerr  = rsel && (!amap || !szok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) begin
        mode[i] <= '0;
        base[i] <= '0;
        cnt[i]  <= '0;
      end
      run   <= '0;
      rdata <= '0;
      err   <= 1'b0;
      uflow <= '0;
    end else begin
      err   <= werr || rerr;
      uflow <= ufc & top;
      if (rsel) rdata <= rerr ? '0 : rv;
      for (int i = 0; i < NT; i++) begin
        if (ufc[i])      cnt[i] <= base[i];
        else if (stp[i]) cnt[i] <= cnt[i] - 1'b1;
      end
      if (wbase) begin
        for (int k = 0; k < NT; k++) begin
          if (lanes[k]) begin
            base[k] <= wb[k];
            if (!busy[k]) cnt[k] <= wb[k];
          end
        end
      end
      if (wmode) begin
        mode[idx] <= mv;
        if (start) begin
          run[idx] <= nz;
          for (int k = 0; k < NT; k++) if (chain[k]) cnt[k] <= base[k];
        end else begin
          run[idx] <= 1'b0;
          if (mv[6]) cnt[idx] <= base[idx];
        end
      end
    end
  end

  AST_LOWEST_NOT_CASCADED: assert property (@(posedge clk) disable iff (!rst_n)
    mode[0][1:0] != SRC_CAS); // R3

  for (genvar g = 0; g < NT; g++) begin : g_chk
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      mode[g][5:2] == 4'd0); // R3
    AST_NO_LOAD_AND_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode[g][7] && mode[g][6])); // R3
    AST_ERR_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> mode[g] == $past(mode[g])); // R3
    AST_RELOAD_ON_UFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      uflow[g] |-> cnt[g] == $past(base[g])); // R4
    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy[g] && !wr_en) |=> $stable(cnt[g])); // R11
    if (g < NT-1) begin : g_top
      AST_UFLOW_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        uflow[g] |-> !$past(cas[g+1])); // R6
    end
  end
endmodule

// File: tb/sim_tmr_cascade_bank.sv
module sim_tmr_cascade_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tick_en = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         err;
  wire  [3:0]  uflow;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_cascade_bank u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .size(size), .wdata(wdata), .rdata(rdata),
    .err(err), .uflow(uflow));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus(input logic w, input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
    wr_en = w; rd_en = !w; addr = a; size = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [1:0] s,
                    input logic [31:0] d, input logic exp_err);
    bus(1'b1, a, s, d);
    chk(tag, {31'd0, err}, {31'd0, exp_err});
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [1:0] s, input logic [31:0] exp);
    bus(1'b0, a, s, 32'd0);
    chk(tag, rdata, exp);
  endtask

  task automatic tk(input logic [3:0] m);
    tick_en = m;
    @(negedge clk);
    tick_en = '0;
  endtask

  function automatic logic [31:0] swap4(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1_uflow", {28'd0, uflow}, 32'd0);
    chk("R1_err", {31'd0, err}, 32'd0);
    rd("R1_mode", 8'h00, 2'd2, 32'd0);
    rd("R1_base", 8'h10, 2'd2, 32'd0);
    rd("R1_cnt", 8'h20, 2'd2, 32'd0);

    // R10 access sizes and byte order
    wr("R10_w4", 8'h10, 2'd2, 32'h11223344, 1'b0);
    for (int k = 0; k < 4; k++)
      rd("R10_r1", 8'h10 + 8'(k), 2'd0, (32'h11223344 >> (8 * (3 - k))) & 32'hFF);
    rd("R10_r2", 8'h12, 2'd1, 32'h3344);
    wr("R10_odd2", 8'h11, 2'd1, 32'hAAAA, 1'b1);
    wr("R10_bad4", 8'h12, 2'd2, 32'hAAAAAAAA, 1'b1);
    wr("R10_sz3", 8'h10, 2'd3, 32'hAAAAAAAA, 1'b1);
    rd("R10_kept", 8'h10, 2'd2, 32'h11223344);
    bus(1'b0, 8'h13, 2'd1, 32'd0);
    chk("R10_rderr", {31'd0, err}, 32'd1);
    wr("R10_unmap", 8'h34, 2'd0, 32'h1, 1'b1);
    // R9 stopped counter reads base, counter write refused
    rd("R9_stopped", 8'h20, 2'd2, 32'h11223344);
    wr("R9_cntwr", 8'h21, 2'd0, 32'h5, 1'b1);
    rd("R9_kept", 8'h21, 2'd0, 32'h22);

    // R3 illegal mode writes, R2 readback
    wr("R2_mode1", 8'h01, 2'd0, 32'h01, 1'b0);
    wr("R3_ldcne", 8'h01, 2'd0, 32'hC0, 1'b1);
    rd("R3_keep1", 8'h01, 2'd0, 32'h01);
    wr("R3_resv", 8'h01, 2'd0, 32'h04, 1'b1);
    rd("R3_keep2", 8'h01, 2'd0, 32'h01);
    wr("R3_t0cas", 8'h00, 2'd0, 32'h03, 1'b1);
    wr("R3_t0cas_run", 8'h00, 2'd0, 32'h83, 1'b1);
    wr("R3_size", 8'h02, 2'd1, 32'h0001, 1'b1);
    rd("R2_mode4", 8'h00, 2'd2, 32'h00010000);

    // R4 period sweep on timer 1
    for (int b = 1; b <= 12; b++) begin
      do_reset();
      wr("R4_base", 8'h11, 2'd0, 32'(b), 1'b0);
      wr("R4_start", 8'h01, 2'd0, 32'h80, 1'b0);
      for (int k = 1; k <= b + 1; k++) begin
        tk((k % 2 == 1) ? 4'b0010 : 4'b1111);
        chk("R4_uflow", {28'd0, uflow}, (k == b + 1) ? 32'h2 : 32'h0);
        rd("R4_cnt", 8'h21, 2'd0, (k == b + 1) ? 32'(b) : 32'(b - k));
      end
      tk(4'b1101);
      rd("R4_notick", 8'h21, 2'd0, 32'(b));
    end

    // R5 base write while running; R11 stop and restart
    do_reset();
    wr("R5_base", 8'h10, 2'd0, 32'd4, 1'b0);
    wr("R5_start", 8'h00, 2'd0, 32'h80, 1'b0);
    tk(4'b0001);
    rd("R5_cnt3", 8'h20, 2'd0, 32'd3);
    wr("R5_newbase", 8'h10, 2'd0, 32'd9, 1'b0);
    rd("R5_hold", 8'h20, 2'd0, 32'd3);
    rd("R5_basev", 8'h10, 2'd0, 32'd9);
    repeat (3) tk(4'b0001);
    rd("R5_zero", 8'h20, 2'd0, 32'd0);
    tk(4'b0001);
    chk("R5_uflow", {28'd0, uflow}, 32'h1);
    rd("R5_reload", 8'h20, 2'd0, 32'd9);
    tk(4'b0001);
    wr("R11_stop", 8'h00, 2'd0, 32'h00, 1'b0);
    rd("R11_rdbase", 8'h20, 2'd0, 32'd9);
    tk(4'b0001);
    rd("R11_still", 8'h20, 2'd0, 32'd9);
    wr("R11_restart", 8'h00, 2'd0, 32'h80, 1'b0);
    tk(4'b0001);
    rd("R11_fresh", 8'h20, 2'd0, 32'd8);

    // R8 zero base does not start
    do_reset();
    wr("R8_start0", 8'h01, 2'd0, 32'h80, 1'b0);
    tk(4'b0010);
    chk("R8_nouf", {28'd0, uflow}, 32'd0);
    wr("R8_base", 8'h11, 2'd0, 32'd5, 1'b0);
    repeat (3) tk(4'b0010);
    chk("R8_nouf2", {28'd0, uflow}, 32'd0);
    rd("R8_cnt", 8'h21, 2'd0, 32'd5);
    wr("R8_start", 8'h01, 2'd0, 32'h80, 1'b0);
    tk(4'b0010);
    rd("R8_runs", 8'h21, 2'd0, 32'd4);

    // R7 cascaded upper timer not enabled
    do_reset();
    wr("R7_base", 8'h12, 2'd0, 32'd5, 1'b0);
    wr("R7_cas", 8'h03, 2'd0, 32'h03, 1'b0);
    wr("R7_refuse", 8'h02, 2'd0, 32'h80, 1'b1);
    rd("R7_mode", 8'h02, 2'd0, 32'h00);
    tk(4'b0100);
    rd("R7_nocount", 8'h22, 2'd0, 32'd5);
    wr("R7_casen", 8'h03, 2'd0, 32'h83, 1'b0);
    wr("R7_accept", 8'h02, 2'd0, 32'h80, 1'b0);
    for (int k = 1; k <= 6; k++) begin
      tk(4'b0100);
      chk("R6_short_uf", {28'd0, uflow}, (k == 6) ? 32'h8 : 32'h0);
    end

    // R6 16-bit chain of timers 2 and 3, combined base 0x0102
    do_reset();
    wr("R6_cas3", 8'h03, 2'd0, 32'h83, 1'b0);
    wr("R6_base", 8'h12, 2'd1, 32'h0201, 1'b0);
    wr("R6_start", 8'h02, 2'd0, 32'h80, 1'b0);
    for (int k = 1; k <= 259; k++) begin
      logic [15:0] v;
      v = (k == 259) ? 16'd258 : 16'(258 - k);
      tk((k % 3 == 0) ? 4'b1100 : 4'b0100);
      chk("R6_uflow16", {28'd0, uflow}, (k == 259) ? 32'h8 : 32'h0);
      rd("R6_cnt16", 8'h22, 2'd1, {16'd0, v[7:0], v[15:8]});
    end

    // R6 32-bit chain, combined base 0x100, borrow across bytes
    do_reset();
    wr("R6_c1", 8'h01, 2'd0, 32'h83, 1'b0);
    wr("R6_c2", 8'h02, 2'd0, 32'h83, 1'b0);
    wr("R6_c3", 8'h03, 2'd0, 32'h83, 1'b0);
    wr("R6_b32", 8'h10, 2'd2, 32'h00010000, 1'b0);
    wr("R6_s32", 8'h00, 2'd0, 32'h80, 1'b0);
    rd("R2_modes", 8'h00, 2'd2, 32'h80838383);
    for (int k = 1; k <= 257; k++) begin
      logic [31:0] v;
      v = (k == 257) ? 32'd256 : 32'(256 - k);
      tk(4'b0001);
      chk("R6_uflow32", {28'd0, uflow}, (k == 257) ? 32'h8 : 32'h0);
      rd("R6_cnt32", 8'h20, 2'd2, swap4(v));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule